// File: doc/BRIEF.md
# Closed-Loop Standby Supply Step Controller

This controller runs the feedback loop that lowers an SRAM array's standby supply until a row of replica "canary" cells starts to lose data, then holds the supply one step above that point. The canaries are built to fail at a slightly higher voltage than the real cells, so the supply tracks process, voltage and temperature drift while the array data stays safe. The controller turns on canary failure sensing and waits a programmed number of cycles for the sense result. If no canary has flipped, it asks an external regulator for one code step down, where one code is 10 mV. If a canary has flipped, it asks for one code step up, turns sensing off and drives the canary write strobe so that every canary holds its known value again before the next check.

Every regulator request is a single-cycle pulse, and the controller sends no new request until the regulator acknowledges the previous one. A mirror of the supply code sets the limits of the walk. Lowering stops at a floor code. When standby ends, the controller raises the supply step by step back to the ceiling code and then goes quiet. A separate one-cycle pulse clears the canary bias controls when standby ends, and again after every set number of completed sense-and-rewrite cycles.

Top module: `sby_step_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, det_en, step_down, step_up, canary_wr and bias_clr are all low, and the internal code mirror is at CEIL_CODE.
- R2: While standby_req is high and the controller is sensing, det_en is high. If canary_fail is low at the end of a DET_CYC-cycle sensing window, exactly one step_down pulse follows.
- R3: step_down and step_up are one cycle wide and are never high together. After either pulse, no further request is issued until step_done has been seen.
- R4: If canary_fail is high at the end of a sensing window, exactly one step_up pulse follows, and no step_down comes before the canary rewrite.
- R5: Once the raise after a failure has been acknowledged, det_en goes low and canary_wr stays high for exactly WR_CYC cycles (default 4). det_en is never high while canary_wr is high. Sensing then resumes.
- R6: bias_clr gives a one-cycle pulse in the cycle after every CLR_EVERY-th completed canary rewrite.
- R7: A high-to-low transition of standby_req gives a one-cycle bias_clr pulse in the following cycle.
- R8: After standby_req falls, the controller issues step_up requests one at a time until the code mirror reaches CEIL_CODE. It then issues no more requests, and det_en stays low.
- R9: No step_down is issued when the code mirror equals FLOOR_CODE. Sensing continues at the floor without any further requests.
- R10: Each request changes the supply code by exactly one step, so the net count of down and up pulses equals the change in regulator code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_req | input | 1 | High while the array is in standby and the loop may scale the supply |
| canary_fail | input | 1 | High when at least one canary row has flipped |
| step_done | input | 1 | Regulator acknowledge for the outstanding step request |
| det_en | output | 1 | Enables canary failure sensing |
| step_down | output | 1 | One-cycle request to lower the supply by one code |
| step_up | output | 1 | One-cycle request to raise the supply by one code |
| canary_wr | output | 1 | Write strobe that restores the canary cells |
| bias_clr | output | 1 | One-cycle pulse that clears all canary bias controls |

## Verification
The bench builds the controller with CEIL_CODE 20, FLOOR_CODE 2, DET_CYC 4, WR_CYC 3 and CLR_EVERY 2, and runs it against a regulator model that acknowledges two cycles after each request. The short ceiling-to-floor span lets a run with no canary failures reach the floor after 18 steps, so the floor stop falls inside a short test. A clear interval of two lets the periodic bias clear wrap twice within four rewrites. The non-default rewrite length checks that the strobe width comes from the parameter. A sticky canary model that fails below code 15 makes the loop settle and oscillate between codes 14 and 15, which exercises the full down, fail, up and rewrite ordering several times before standby ends.

// File: rtl/sby_step_pkg.sv
package sby_step_pkg;

    // Loop sequencing states
    typedef enum logic [2:0] {
        ST_SENSE   = 3'd0,
        ST_HOLD    = 3'd1,
        ST_FLIP    = 3'd2,
        ST_REWRITE = 3'd3,
        ST_RECOVER = 3'd4
    } loop_state_e;

    // One-cycle step request from the sequencer to the issuer
    typedef struct packed {
        logic dn;
        logic up;
    } step_req_t;

    // Width of a counter that runs from 0 to n-1
    function automatic int cnt_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sby_step_issuer.sv
module sby_step_issuer
    import sby_step_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int CEIL_CODE  = 40,
    parameter int FLOOR_CODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  step_req_t         req,
    input  logic              step_done,
    output logic              step_down,
    output logic              step_up,
    output logic              busy,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] CEIL_V  = CODE_W'(CEIL_CODE);
    localparam logic [CODE_W-1:0] FLOOR_V = CODE_W'(FLOOR_CODE);

    logic at_floor;
    logic at_ceil;

    assign at_floor = (code == FLOOR_V);
    assign at_ceil  = (code == CEIL_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_down <= 1'b0;
            step_up   <= 1'b0;
            busy      <= 1'b0;
            code      <= CEIL_V;
        end else begin
            step_down <= 1'b0;
            step_up   <= 1'b0;
            if (busy) begin
                if (step_done) begin
                    busy <= 1'b0;
                end
            end else if (req.dn && !at_floor) begin
                step_down <= 1'b1;
                busy      <= 1'b1;
                code      <= code - 1'b1;
            end else if (req.up && !at_ceil) begin
                step_up   <= 1'b1;
                busy      <= 1'b1;
                code      <= code + 1'b1;
            end
        end
    end

    // R3: the two directions are never requested together
    p_one_dir_r3: assert property (@(posedge clk) disable iff (rst)
        !(step_down && step_up));

    // R3: a request outstanding without acknowledge blocks the next one
    p_wait_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !step_done) |=> !(step_down || step_up));

    // R9: a downward request never leaves the mirror below the floor
    p_floor_r9: assert property (@(posedge clk) disable iff (rst)
        step_down |-> ($past(code) != FLOOR_V));

    // R8: an upward request never takes the mirror past the ceiling
    p_ceil_r8: assert property (@(posedge clk) disable iff (rst)
        step_up |-> ($past(code) != CEIL_V));

endmodule

// File: rtl/sby_rewrite_timer.sv
module sby_rewrite_timer
    import sby_step_pkg::*;
#(
    parameter int WR_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic last
);

    localparam int WR_W = cnt_w(WR_CYC);
    localparam logic [WR_W-1:0] WR_LAST = WR_W'(WR_CYC - 1);

    logic [WR_W-1:0] cnt;

    assign last = active && (cnt == WR_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!active || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sby_check_tally.sv
module sby_check_tally
    import sby_step_pkg::*;
#(
    parameter int CLR_EVERY = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic rewrite_done,
    input  logic standby,
    output logic bias_clr
);

    localparam int TL_W = cnt_w(CLR_EVERY);
    localparam logic [TL_W-1:0] TL_LAST = TL_W'(CLR_EVERY - 1);

    logic [TL_W-1:0] tally;
    logic            prev_sb;
    logic            wrap;
    logic            armed;

    assign wrap = rewrite_done && (tally == TL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tally    <= '0;
            prev_sb  <= 1'b0;
            bias_clr <= 1'b0;
            armed    <= 1'b0;
        end else begin
            armed    <= 1'b1;
            prev_sb  <= standby;
            bias_clr <= (prev_sb && !standby) || wrap;
            if (rewrite_done) begin
                tally <= wrap ? '0 : tally + 1'b1;
            end
        end
    end

    // R7: leaving standby is followed by a clear pulse
    p_leave_clr_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(standby) |=> bias_clr);

    // R6: a pulse with no standby exit must come from a completed rewrite
    p_tally_clr_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        (bias_clr && $past(standby) == $past(prev_sb)) |-> $past(rewrite_done));

endmodule

// File: rtl/sby_step_ctrl.sv
module sby_step_ctrl
    import sby_step_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int CEIL_CODE  = 40,
    parameter int FLOOR_CODE = 0,
    parameter int DET_CYC    = 8,
    parameter int WR_CYC     = 4,
    parameter int CLR_EVERY  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic standby_req,
    input  logic canary_fail,
    input  logic step_done,
    output logic det_en,
    output logic step_down,
    output logic step_up,
    output logic canary_wr,
    output logic bias_clr
);

    localparam int DET_W = cnt_w(DET_CYC);
    localparam logic [DET_W-1:0] DET_LAST = DET_W'(DET_CYC - 1);
    localparam logic [CODE_W-1:0] CEIL_V  = CODE_W'(CEIL_CODE);

    loop_state_e       state, state_n;
    logic [DET_W-1:0]  det_cnt, det_cnt_n;
    logic              issued, issued_n;
    step_req_t         req;
    logic              busy;
    logic [CODE_W-1:0] code;
    logic              wr_last;

    sby_step_issuer #(
        .CODE_W     (CODE_W),
        .CEIL_CODE  (CEIL_CODE),
        .FLOOR_CODE (FLOOR_CODE)
    ) u_issuer (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .step_done (step_done),
        .step_down (step_down),
        .step_up   (step_up),
        .busy      (busy),
        .code      (code)
    );

    sby_rewrite_timer #(
        .WR_CYC (WR_CYC)
    ) u_rewrite (
        .clk    (clk),
        .rst    (rst),
        .active (canary_wr),
        .last   (wr_last)
    );

    sby_check_tally #(
        .CLR_EVERY (CLR_EVERY)
    ) u_tally (
        .clk          (clk),
        .rst          (rst),
        .rewrite_done (wr_last),
        .standby      (standby_req),
        .bias_clr     (bias_clr)
    );

    always_comb begin
        state_n   = state;
        det_cnt_n = det_cnt;
        issued_n  = issued;
        req       = '0;
        unique case (state)
            ST_SENSE: begin
                if (!standby_req) begin
                    det_cnt_n = '0;
                    if (code != CEIL_V) begin
                        state_n = ST_RECOVER;
                    end
                end else if (det_cnt == DET_LAST) begin
                    det_cnt_n = '0;
                    state_n   = canary_fail ? ST_FLIP : ST_HOLD;
                end else begin
                    det_cnt_n = det_cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!issued) begin
                    req.dn   = 1'b1;
                    issued_n = 1'b1;
                end else if (!busy) begin
                    issued_n = 1'b0;
                    state_n  = ST_SENSE;
                end
            end
            ST_FLIP: begin
                if (!issued) begin
                    req.up   = 1'b1;
                    issued_n = 1'b1;
                end else if (!busy) begin
                    issued_n = 1'b0;
                    state_n  = ST_REWRITE;
                end
            end
            ST_REWRITE: begin
                if (wr_last) begin
                    state_n = ST_SENSE;
                end
            end
            ST_RECOVER: begin
                if (!busy) begin
                    if (standby_req || code == CEIL_V) begin
                        state_n = ST_SENSE;
                    end else begin
                        req.up = 1'b1;
                    end
                end
            end
            default: state_n = ST_SENSE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_SENSE;
            det_cnt <= '0;
            issued  <= 1'b0;
        end else begin
            state   <= state_n;
            det_cnt <= det_cnt_n;
            issued  <= issued_n;
        end
    end

    assign det_en    = (state == ST_SENSE && standby_req) ||
                       (state == ST_HOLD) || (state == ST_FLIP);
    assign canary_wr = (state == ST_REWRITE);

    // R5: sensing is off for the whole rewrite
    p_wr_no_det_r5: assert property (@(posedge clk) disable iff (rst)
        !(canary_wr && det_en));

    // R4: a rewrite starts only after the raise that follows a failure
    p_flip_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(canary_wr) |-> ($past(state) == ST_FLIP));

    // R5: when the rewrite ends the loop goes back to sensing
    p_back_to_sense_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(canary_wr) |-> (state == ST_SENSE));

    // R2: a down request is issued only from the hold state
    p_dn_from_hold_r2: assert property (@(posedge clk) disable iff (rst)
        step_down |-> ($past(state) == ST_HOLD));

endmodule

// File: tb/tb_sby_step_ctrl.sv
module tb_sby_step_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 6;
    localparam int CEIL       = 20;
    localparam int FLOOR      = 2;
    localparam int DET        = 4;
    localparam int WR         = 3;
    localparam int CLR_N      = 2;
    localparam int LAT        = 2;

    typedef enum int {EV_DN, EV_UP, EV_WR, EV_CLR} ev_e;
    typedef struct {
        ev_e   kind;
        int    arg;
        string req;
    } ev_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic standby_req = 1'b0;
    logic canary_fail = 1'b0;
    logic step_done = 1'b0;
    logic det_en, step_down, step_up, canary_wr, bias_clr;

    int   n_chk = 0;
    int   n_fail = 0;
    int   vreg = CEIL;
    int   pend = 0;
    int   pdir = 0;
    int   overlap = 0;
    int   fail_thr = 0;
    int   wr_run = 0;
    bit   prev_dn = 1'b0;
    bit   prev_up = 1'b0;
    ev_t  exp_q[$];

    sby_step_ctrl #(
        .CODE_W     (CODE_W),
        .CEIL_CODE  (CEIL),
        .FLOOR_CODE (FLOOR),
        .DET_CYC    (DET),
        .WR_CYC     (WR),
        .CLR_EVERY  (CLR_N)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .standby_req (standby_req),
        .canary_fail (canary_fail),
        .step_done   (step_done),
        .det_en      (det_en),
        .step_down   (step_down),
        .step_up     (step_up),
        .canary_wr   (canary_wr),
        .bias_clr    (bias_clr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input ev_e k, input int arg, input string req);
        ev_t e;
        e.kind = k;
        e.arg  = arg;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic take(input ev_e k, input int arg);
        ev_t e;
        if (exp_q.size() == 0) begin
            case (k)
                EV_DN:   check(1'b0, "R9", "unexpected step_down", int'(k), -1);
                EV_UP:   check(1'b0, "R8", "unexpected step_up", int'(k), -1);
                EV_WR:   check(1'b0, "R5", "unexpected rewrite", int'(k), -1);
                default: check(1'b0, "R6", "unexpected bias_clr", int'(k), -1);
            endcase
        end else begin
            e = exp_q.pop_front();
            check(e.kind == k, e.req, "event kind", int'(k), int'(e.kind));
            if (e.kind == EV_WR && k == EV_WR)
                check(e.arg == arg, e.req, "rewrite length", arg, e.arg);
        end
    endtask

    // Regulator and sticky canary model
    initial begin
        forever begin
            @(posedge clk);
            step_done <= 1'b0;
            if (rst) begin
                vreg        <= CEIL;
                pend        <= 0;
                canary_fail <= 1'b0;
            end else begin
                if (canary_wr)
                    canary_fail <= 1'b0;
                else if (vreg < fail_thr)
                    canary_fail <= 1'b1;
                if (pend > 0) begin
                    if (pend == 1) begin
                        vreg      <= vreg + pdir;
                        step_done <= 1'b1;
                    end
                    pend <= pend - 1;
                end
                if (step_down || step_up) begin
                    if (pend > 0) overlap <= overlap + 1;
                    pend <= LAT;
                    pdir <= step_up ? 1 : -1;
                end
            end
        end
    end

    // Monitor: pop and compare as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (step_down || step_up)
                    check(!(step_down && step_up) && !(step_down && prev_dn) &&
                          !(step_up && prev_up), "R3", "pulse shape",
                          {step_down, step_up}, 0);
                if (step_down) take(EV_DN, 0);
                if (step_up) take(EV_UP, 0);
                if (canary_wr) begin
                    check(!det_en, "R5", "det_en during rewrite", det_en, 0);
                    wr_run++;
                end else if (wr_run > 0) begin
                    take(EV_WR, wr_run);
                    wr_run = 0;
                end
                if (bias_clr) take(EV_CLR, 0);
                prev_dn = step_down;
                prev_up = step_up;
            end
        end
    end

    task automatic drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, "R2", "expected events left", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({det_en, step_down, step_up, canary_wr, bias_clr} == 5'b0, "R1",
              "outputs in reset", {det_en, step_down, step_up, canary_wr, bias_clr}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({det_en, step_down, step_up, canary_wr, bias_clr} == 5'b0, "R1",
              "outputs after reset", {det_en, step_down, step_up, canary_wr, bias_clr}, 0);
        repeat (20) @(negedge clk);
        check(vreg == CEIL, "R1", "idle code", vreg, CEIL);

        // Session 1: canary fails below code 15
        fail_thr = 15;
        for (int i = 0; i < 6; i++) push(EV_DN, 0, "R2");
        push(EV_UP, 0, "R4");
        push(EV_WR, WR, "R5");
        for (int i = 0; i < 3; i++) begin
            push(EV_DN, 0, "R2");
            push(EV_UP, 0, "R4");
            push(EV_WR, WR, "R5");
            if ((i % 2) == 0) push(EV_CLR, 0, "R6");
        end
        standby_req = 1'b1;
        @(negedge clk);
        check(det_en == 1'b1, "R2", "det_en while sensing", det_en, 1);
        drain();
        check(vreg == 15, "R10", "settled code", vreg, 15);
        push(EV_CLR, 0, "R7");
        for (int i = 0; i < 5; i++) push(EV_UP, 0, "R8");
        @(negedge clk);
        standby_req = 1'b0;
        drain();
        repeat (30) @(negedge clk);
        check(vreg == CEIL, "R8", "code after exit", vreg, CEIL);
        check(det_en == 1'b0, "R8", "det_en after exit", det_en, 0);

        // Session 2: no failures, walk to the floor
        fail_thr = 0;
        for (int i = 0; i < CEIL - FLOOR; i++) push(EV_DN, 0, "R9");
        standby_req = 1'b1;
        drain();
        repeat (60) @(negedge clk);
        check(vreg == FLOOR, "R9", "code at floor", vreg, FLOOR);
        check(det_en == 1'b1, "R9", "sensing at floor", det_en, 1);
        push(EV_CLR, 0, "R7");
        for (int i = 0; i < CEIL - FLOOR; i++) push(EV_UP, 0, "R8");
        standby_req = 1'b0;
        drain();
        repeat (20) @(negedge clk);
        check(vreg == CEIL, "R10", "code after second exit", vreg, CEIL);
        check(overlap == 0, "R3", "requests before acknowledge", overlap, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule